// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Serial Peripheral Override

This block is an 8-bit general-purpose I/O port on a small register bus. Its pins are shared with one SPI controller and two UART channels. Software sets pin levels through a data register and pin directions through a direction register. A read-only input register shows the synchronized pin levels. When a serial peripheral is enabled, it takes over its own pins. The port then passes that peripheral's direction and output value to the pad instead of the GPIO registers.

Pins 7 to 4 belong to the SPI, which sets their direction while it is enabled. Pin 3 is the transmit pin of UART channel 1 and pin 1 is the transmit pin of UART channel 0. Each is forced to output while its transmitter is enabled. Pin 2 is the receive pin of UART channel 1 and pin 0 is the receive pin of UART channel 0. Each is forced to input while its receiver is enabled. Every other pin behaves as plain GPIO.

Raw pin levels pass through a two-flop synchronizer. The register bus uses a 2-bit address, writes in one cycle and returns read data registered one cycle after the address. The port has no state machine: the only sequencing is the fixed two-stage synchronizer fill after reset.

Top module: `pmux_port`

## Requirements
- R1: After reset the data and direction registers are 0x00, every pin_oe bit is 0, and rdata is 0x00.
- R2: While spi_en is 1, pin_oe[7:4] equals spi_oe and pin_out[7:4] equals spi_out, whatever the direction register holds.
- R3: While uart_tx_en[1] is 1, pin 3 has pin_oe=1 and pin_out=uart_tx_out[1]. While uart_tx_en[0] is 1, pin 1 has pin_oe=1 and pin_out=uart_tx_out[0].
- R4: While uart_rx_en[1] is 1, pin_oe[2] is 0. While uart_rx_en[0] is 1, pin_oe[0] is 0. This holds whatever the direction register holds.
- R5: A pin whose peripheral function is disabled has pin_oe equal to its direction bit and pin_out equal to its data-register bit.
- R6: A read of address 0 (data) returns, per bit, the data-register bit where the direction bit is 1 and the synchronized pin input where it is 0. This depends on the direction register alone, not on peripheral overrides.
- R7: A read of address 1 (input) returns the synchronized pin states whatever the direction and peripheral settings. Writes to address 1 change no register.
- R8: Address 2 (direction) can be written and read back at any time, including while a peripheral overrides pins.
- R9: A pin level reaches the synchronized state two clock edges after it is applied. With address 1 held from reset release, rdata is 0 after the first and second edges and shows the pins after the third.
- R10: rdata is registered one cycle after the address. Address 3 reads as 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register select: 0 data, 1 input, 2 direction, 3 unused |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| spi_en | input | 1 | SPI owns pins 7..4 |
| spi_oe | input | 4 | SPI direction for pins 7..4 |
| spi_out | input | 4 | SPI output value for pins 7..4 |
| uart_tx_en | input | 2 | Transmitter enables, bit 1 pin 3, bit 0 pin 1 |
| uart_tx_out | input | 2 | Transmit values, bit 1 pin 3, bit 0 pin 1 |
| uart_rx_en | input | 2 | Receiver enables, bit 1 pin 2, bit 0 pin 0 |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
A corrupted direction or data register shows on pin_oe and pin_out in the same cycle the bad value is captured. A corrupted register also shows on the next read of address 0 or 2, one cycle after the address is presented. A synchronizer stage that is stuck or skipped moves the input register's first valid read off the third edge after reset release. A wrong override selection shows at once on the pins of the affected group, such as the SPI nibble or a UART transmit or receive pin.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_PINS  = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pmux_regs.sv
module pmux_regs
    import pmux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pins_sync,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      rdata
);
    reg_sel_e     sel;
    logic [W-1:0] rd_next;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_LATCH: latch_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_PINS, SEL_NONE: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_LATCH: rd_next = (dir_q & latch_q) | (~dir_q & pins_sync);
            SEL_PINS:  rd_next = pins_sync;
            SEL_DIR:   rd_next = dir_q;
            SEL_NONE:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end
endmodule

// File: rtl/pmux_route.sv
module pmux_route #(
    parameter int W     = 8,
    parameter int SPI_W = 4
) (
    input  logic [W-1:0]     latch_q,
    input  logic [W-1:0]     dir_q,
    input  logic             spi_en,
    input  logic [SPI_W-1:0] spi_oe,
    input  logic [SPI_W-1:0] spi_out,
    input  logic [1:0]       uart_tx_en,
    input  logic [1:0]       uart_tx_out,
    input  logic [1:0]       uart_rx_en,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     pin_out
);
    localparam int SPI_LO = W - SPI_W;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i >= SPI_LO) begin : g_spi
            assign pin_oe[i]  = spi_en ? spi_oe[i-SPI_LO]  : dir_q[i];
            assign pin_out[i] = spi_en ? spi_out[i-SPI_LO] : latch_q[i];
        end else if (i == 3 || i == 1) begin : g_tx
            localparam int CH = (i == 3) ? 1 : 0;
            assign pin_oe[i]  = uart_tx_en[CH] | dir_q[i];
            assign pin_out[i] = uart_tx_en[CH] ? uart_tx_out[CH] : latch_q[i];
        end else if (i == 2 || i == 0) begin : g_rx
            localparam int CH = (i == 2) ? 1 : 0;
            assign pin_oe[i]  = ~uart_rx_en[CH] & dir_q[i];
            assign pin_out[i] = latch_q[i];
        end else begin : g_plain
            assign pin_oe[i]  = dir_q[i];
            assign pin_out[i] = latch_q[i];
        end
    end
endmodule

// File: rtl/pmux_port.sv
module pmux_port
    import pmux_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic              spi_en,
    input  logic [3:0]        spi_oe,
    input  logic [3:0]        spi_out,
    input  logic [1:0]        uart_tx_en,
    input  logic [1:0]        uart_tx_out,
    input  logic [1:0]        uart_rx_en,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out
);
    localparam int SPI_W = 4;

    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;

    pmux_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pins_sync)
    );

    pmux_regs #(.W(PORT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .pins_sync (pins_sync),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .rdata     (rdata)
    );

    pmux_route #(.W(PORT_W), .SPI_W(SPI_W)) u_route (
        .latch_q     (latch_q),
        .dir_q       (dir_q),
        .spi_en      (spi_en),
        .spi_oe      (spi_oe),
        .spi_out     (spi_out),
        .uart_tx_en  (uart_tx_en),
        .uart_tx_out (uart_tx_out),
        .uart_rx_en  (uart_rx_en),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out)
    );
endmodule

// File: rtl/pmux_port_chk.sv
module pmux_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       spi_en,
    input logic [3:0] spi_oe,
    input logic [3:0] spi_out,
    input logic [1:0] uart_tx_en,
    input logic [1:0] uart_tx_out,
    input logic [1:0] uart_rx_en,
    input logic [7:0] pin_in,
    input logic [7:0] pin_oe,
    input logic [7:0] pin_out
);
    // R2
    spi_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (pin_oe[7:4] == spi_oe && pin_out[7:4] == spi_out));

    // R3
    tx_forced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uart_tx_en[1] |-> (pin_oe[3] && pin_out[3] == uart_tx_out[1]));

    // R4
    rx_forced_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_rx_en[0] || uart_rx_en[1]) |->
            ((!uart_rx_en[0] || !pin_oe[0]) && (!uart_rx_en[1] || !pin_oe[2])));

    // R5
    dir_write_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && addr == 2'd2) && !spi_en) |->
            (pin_oe[7:4] == $past(wdata[7:4])));

    // R10
    unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr) == 2'd3) |-> (rdata == 8'h00));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_all_inputs_chk: assert (pin_oe == 8'h00);
        end
    end
endmodule

bind pmux_port pmux_port_chk u_chk (.*);

// File: tb/pmux_port_bench.sv
module pmux_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       spi_en = 1'b0;
    logic [3:0] spi_oe = 4'h0;
    logic [3:0] spi_out = 4'h0;
    logic [1:0] uart_tx_en = 2'b00;
    logic [1:0] uart_tx_out = 2'b00;
    logic [1:0] uart_rx_en = 2'b00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pmux_port u_pmux_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .spi_en(spi_en), .spi_oe(spi_oe), .spi_out(spi_out),
        .uart_tx_en(uart_tx_en), .uart_tx_out(uart_tx_out),
        .uart_rx_en(uart_rx_en), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data once its cycle has come
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, rdata, it.exp);
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        addr = a;
        it.due = cyc + 1; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        pin_in = 8'hA5;
        addr = 2'd1;
        settle(3);
        check("R1 oe in reset", pin_oe, 8'h00);
        check("R1 rdata in reset", rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); check("R9 edge1", rdata, 8'h00);
        @(negedge clk); check("R9 edge2", rdata, 8'h00);
        @(negedge clk); check("R9 edge3", rdata, 8'hA5);
        bus_read(2'd2, 8'h00, "R1 dir reset");
        bus_read(2'd0, 8'hA5, "R6 all-input data read");
        check("R1 oe after reset", pin_oe, 8'h00);

        bus_write(2'd0, 8'h5A);
        bus_write(2'd2, 8'hF0);
        check("R5 oe from dir", pin_oe, 8'hF0);
        check("R5 out from latch", pin_out, 8'h5A);
        bus_read(2'd0, 8'h55, "R6 mixed dir F0");
        bus_read(2'd2, 8'hF0, "R8 dir readback");
        bus_write(2'd2, 8'h0F);
        check("R5 oe dir 0F", pin_oe, 8'h0F);
        bus_read(2'd0, 8'hAA, "R6 mixed dir 0F");

        spi_en = 1'b1; spi_oe = 4'b1010; spi_out = 4'b0110;
        #1;
        check("R2 spi oe", {4'h0, pin_oe[7:4]}, 8'h0A);
        check("R2 spi out", {4'h0, pin_out[7:4]}, 8'h06);
        check("R5 low nibble unaffected", {4'h0, pin_oe[3:0]}, 8'h0F);
        @(negedge clk);
        bus_write(2'd2, 8'hFF);
        check("R2 dir ignored under spi", {4'h0, pin_oe[7:4]}, 8'h0A);
        bus_read(2'd2, 8'hFF, "R8 dir write under spi");
        spi_en = 1'b0;
        #1;
        check("R5 spi released", pin_oe, 8'hFF);
        @(negedge clk);

        bus_write(2'd2, 8'h00);
        uart_tx_en = 2'b11; uart_tx_out = 2'b10;
        #1;
        check("R3 tx forced oe", pin_oe, 8'h0A);
        check("R3 tx values", {6'h0, pin_out[3], pin_out[1]}, 8'h02);
        uart_tx_out = 2'b01;
        #1;
        check("R3 tx values swap", {6'h0, pin_out[3], pin_out[1]}, 8'h01);
        @(negedge clk);
        bus_write(2'd2, 8'hFF);
        uart_rx_en = 2'b11;
        #1;
        check("R4 rx forced in", pin_oe, 8'hFA);
        uart_rx_en = 2'b01;
        #1;
        check("R4 rx ch0 only", pin_oe, 8'hFE);
        @(negedge clk);
        bus_read(2'd0, 8'h5A, "R6 dir bit rules despite rx");

        pin_in = 8'h3C;
        settle(3);
        bus_read(2'd1, 8'h3C, "R7 input reg");
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, 8'h3C, "R7 input write ignored");
        bus_read(2'd0, 8'h5A, "R7 latch untouched");
        bus_write(2'd3, 8'h77);
        bus_read(2'd3, 8'h00, "R10 unused reads zero");
        bus_read(2'd2, 8'hFF, "R10 dir untouched");
        bus_read(2'd0, 8'h5A, "R10 latch untouched");
        settle(2);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule